// File: doc/BRIEF.md
# Snooping Bus Arbiter with Conflict Restart

This block decides which of N cache controllers may drive a shared snooping bus. Each controller raises a request that carries a block address and a two-bit coherence command. The arbiter picks one requester in round-robin order and latches that requester's address and command onto the broadcast bus. It holds the grant until the owner reports completion. A controller may change the state of a line only once it sees its grant bit high. Because a single owner holds the bus at any time, every write is placed in one global order.

Transactions run in two phases. In the arbitration phase the bus is free and a winner is chosen. In the ownership phase the winner's command is broadcast until it signals done. The bus can be taken while another controller still waits for a transaction to the same cache block. In that case the arbiter pulses a restart to the waiting controller, which must first deal with the snooped transaction and then drop and reissue its request. The new request may carry a different command. Until the controller withdraws, its stale request is kept out of arbitration.

Top module: `coh_bus_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, grant_o, bus_valid_o and restart_o are all zero.
- R2: At most one grant bit is ever high. bus_valid_o is high exactly when a grant is held, and bus_owner_o gives the index of the granted requester.
- R3: When the bus is free and at least one eligible request is present at a clock edge, the winner's grant is high after that edge. bus_addr_o and bus_cmd_o then equal the winner's address and command as they were sampled at that edge.
- R4: The winner is the first eligible requester found by searching upward from the last granted index plus one, wrapping around from N-1 to 0. After reset, index 0 is searched first.
- R5: While the grant is held, bus_addr_o, bus_cmd_o and bus_owner_o stay constant, even if the owner changes its request inputs.
- R6: The grant stays high until done_i is high at the owner's index. It drops at the next edge. A done_i bit at any other index has no effect on the grant.
- R7: After a grant is released, there is at least one cycle with no grant before the next grant begins.
- R8: While the bus is owned, a non-owner with a valid, unblocked request receives a restart pulse lasting exactly one cycle if its block address (address bits above OFFS) equals that of bus_addr_o. A different byte offset within the same block still counts as a conflict. A request to a different block gets no restart.
- R9: A requester that was restarted is not granted until it has held its request low for at least one cycle. After it reissues, it competes like any other requester.
- R10: Commands are passed to the bus unchanged as the two-bit code: 0 read miss, 1 write miss, 2 upgrade, 3 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | N | Request valid for each requester |
| req_addr_i | input | N*AW | Requester addresses; requester i uses bits [i*AW +: AW] |
| req_cmd_i | input | N*2 | Requester commands; requester i uses bits [i*2 +: 2] |
| done_i | input | N | Completion signal; only the owner's bit counts |
| grant_o | output | N | One-hot bus grant |
| bus_valid_o | output | 1 | The bus is owned and the broadcast is valid |
| bus_addr_o | output | AW | Broadcast block address |
| bus_cmd_o | output | 2 | Broadcast command |
| bus_owner_o | output | $clog2(N) | Index of the owner |
| restart_o | output | N | One-cycle restart pulse for each requester |

## Verification
The bench builds the block with N=4, AW=8 and OFFS=2. With four requesters there are only sixty possible pairs of last-granted index and nonzero request mask. The bench visits all of them and computes the round-robin winner arithmetically for each. The 8-bit address with a 4-byte block makes it easy to set up a same-block conflict at a different offset next to a different-block request. This covers the restart pulse, the blocking of a stale request and its acceptance after reissue.

// File: rtl/cba_pkg.sv
package cba_pkg;

    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_RD  = 2'd0,
        CMD_RDX = 2'd1,
        CMD_UPG = 2'd2,
        CMD_WB  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        PH_ARB = 1'b0,
        PH_OWN = 1'b1
    } phase_e;

    function automatic int wrap_idx(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/cba_rr_pick.sv
module cba_rr_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig_i,
    input  logic [IW-1:0] last_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    import cba_pkg::*;

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = wrap_idx(int'(last_i), k, N);
            if (!valid_o && elig_i[j]) begin
                valid_o = 1'b1;
                idx_o   = IW'(j);
            end
        end
    end

    // R4: the picked index always carries an eligible request
    always_comb begin
        if (valid_o) begin
            assert_pick_elig_R4: assert (elig_i[idx_o]);
        end
    end

endmodule

// File: rtl/cba_conflict.sv
module cba_conflict #(
    parameter int N    = 4,
    parameter int AW   = 32,
    parameter int OFFS = 6,
    parameter int IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    input  logic [IW-1:0] owner_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [N-1:0]  req_valid_i,
    input  logic [N*AW-1:0] req_addr_i,
    output logic [N-1:0]  restart_o,
    output logic [N-1:0]  elig_o
);
    localparam int BW = AW - OFFS;

    logic [N-1:0] blocked_q;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_req
        logic same_blk;
        assign same_blk = (req_addr_i[i*AW+OFFS +: BW] == bus_addr_i[AW-1:OFFS]);
        assign hit[i]   = busy_i && req_valid_i[i] && !blocked_q[i]
                          && (owner_i != IW'(i)) && same_blk;

        // R8: a restart is a single-cycle pulse
        assert_restart_pulse_R8: assert property (@(posedge clk) disable iff (rst)
            restart_o[i] |=> !restart_o[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked_q <= '0;
        end else begin
            blocked_q <= (blocked_q | hit) & req_valid_i;
        end
    end

    assign restart_o = hit;
    assign elig_o    = req_valid_i & ~blocked_q;

endmodule

// File: rtl/cba_bus_seq.sv
module cba_bus_seq #(
    parameter int N  = 4,
    parameter int AW = 32,
    parameter int IW = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pick_valid_i,
    input  logic [IW-1:0]           pick_idx_i,
    input  logic [N*AW-1:0]         req_addr_i,
    input  logic [N*cba_pkg::CMD_W-1:0] req_cmd_i,
    input  logic [N-1:0]            done_i,
    output logic                    busy_o,
    output logic [IW-1:0]           owner_o,
    output logic [AW-1:0]           addr_o,
    output cba_pkg::bus_cmd_e       cmd_o,
    output logic [IW-1:0]           last_o
);
    import cba_pkg::*;

    phase_e        phase_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] last_q;
    logic [AW-1:0] addr_q;
    bus_cmd_e      cmd_q;
    logic          owner_done;

    assign owner_done = done_i[owner_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ARB;
            owner_q <= '0;
            last_q  <= IW'(N - 1);
            addr_q  <= '0;
            cmd_q   <= CMD_RD;
        end else begin
            case (phase_q)
                PH_ARB: begin
                    if (pick_valid_i) begin
                        phase_q <= PH_OWN;
                        owner_q <= pick_idx_i;
                        last_q  <= pick_idx_i;
                        addr_q  <= req_addr_i[pick_idx_i*AW +: AW];
                        cmd_q   <= bus_cmd_e'(req_cmd_i[pick_idx_i*CMD_W +: CMD_W]);
                    end
                end
                PH_OWN: begin
                    if (owner_done) begin
                        phase_q <= PH_ARB;
                    end
                end
                default: phase_q <= PH_ARB;
            endcase
        end
    end

    assign busy_o  = (phase_q == PH_OWN);
    assign owner_o = owner_q;
    assign addr_o  = addr_q;
    assign cmd_o   = cmd_q;
    assign last_o  = last_q;

    // R3: a free bus with a winner becomes owned at the next edge
    assert_arb_to_own_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ARB && pick_valid_i) |=> (phase_q == PH_OWN));

    // R5, R6: ownership and broadcast hold until the owner signals done
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_OWN && !owner_done) |=>
        (phase_q == PH_OWN && $stable(owner_q) && $stable(addr_q) && $stable(cmd_q)));

    // R6: the owner's done frees the bus at the next edge
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_OWN && owner_done) |=> (phase_q == PH_ARB));

endmodule

// File: rtl/coh_bus_arb.sv
module coh_bus_arb #(
    parameter int N    = 4,
    parameter int AW   = 32,
    parameter int OFFS = 6,
    localparam int IW  = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            req_valid_i,
    input  logic [N*AW-1:0]         req_addr_i,
    input  logic [N*2-1:0]          req_cmd_i,
    input  logic [N-1:0]            done_i,
    output logic [N-1:0]            grant_o,
    output logic                    bus_valid_o,
    output logic [AW-1:0]           bus_addr_o,
    output logic [1:0]              bus_cmd_o,
    output logic [IW-1:0]           bus_owner_o,
    output logic [N-1:0]            restart_o
);
    import cba_pkg::*;

    logic          busy;
    logic [IW-1:0] owner;
    logic [IW-1:0] last;
    logic [AW-1:0] baddr;
    bus_cmd_e      bcmd;
    logic [N-1:0]  elig;
    logic          pick_valid;
    logic [IW-1:0] pick_idx;

    cba_conflict #(.N(N), .AW(AW), .OFFS(OFFS), .IW(IW)) u_conflict (
        .clk         (clk),
        .rst         (rst),
        .busy_i      (busy),
        .owner_i     (owner),
        .bus_addr_i  (baddr),
        .req_valid_i (req_valid_i),
        .req_addr_i  (req_addr_i),
        .restart_o   (restart_o),
        .elig_o      (elig)
    );

    cba_rr_pick #(.N(N), .IW(IW)) u_pick (
        .elig_i  (elig),
        .last_i  (last),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    cba_bus_seq #(.N(N), .AW(AW), .IW(IW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .pick_valid_i (pick_valid),
        .pick_idx_i   (pick_idx),
        .req_addr_i   (req_addr_i),
        .req_cmd_i    (req_cmd_i),
        .done_i       (done_i),
        .busy_o       (busy),
        .owner_o      (owner),
        .addr_o       (baddr),
        .cmd_o        (bcmd),
        .last_o       (last)
    );

    assign grant_o     = busy ? (N'(1) << owner) : '0;
    assign bus_valid_o = busy;
    assign bus_addr_o  = baddr;
    assign bus_cmd_o   = bcmd;
    assign bus_owner_o = owner;

    // R2: a valid bus has exactly one grant, at the reported owner
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        bus_valid_o |-> ($onehot(grant_o) && grant_o[bus_owner_o]));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9: a restarted requester is never granted in the following cycle
        assert_no_grant_after_restart_R9: assert property (@(posedge clk) disable iff (rst)
            restart_o[i] |=> !grant_o[i]);
    end

endmodule

// File: tb/coh_bus_arb_tb.sv
`timescale 1ns/1ps
module coh_bus_arb_tb;
    localparam int N = 4, AW = 8, OFFS = 2, IW = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst;
    logic [N-1:0]    req_valid;
    logic [N*AW-1:0] req_addr;
    logic [N*2-1:0]  req_cmd;
    logic [N-1:0]    done;
    logic [N-1:0]    grant;
    logic            bus_valid;
    logic [AW-1:0]   bus_addr;
    logic [1:0]      bus_cmd;
    logic [IW-1:0]   bus_owner;
    logic [N-1:0]    restart;

    coh_bus_arb #(.N(N), .AW(AW), .OFFS(OFFS)) u_dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_cmd_i(req_cmd), .done_i(done), .grant_o(grant), .bus_valid_o(bus_valid),
        .bus_addr_o(bus_addr), .bus_cmd_o(bus_cmd), .bus_owner_o(bus_owner),
        .restart_o(restart)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_req(input int i, input bit v, input logic [AW-1:0] a, input logic [1:0] c);
        req_valid[i]        = v;
        req_addr[i*AW +: AW] = a;
        req_cmd[i*2 +: 2]    = c;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] addr_of(input int i);
        return AW'(i * 16 + 1);
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = '0; req_addr = '0; req_cmd = '0; done = '0;
        tick(); tick();
        chk(grant == 0 && !bus_valid && restart == 0, "R1 in reset", int'(grant), 0);
        #1 rst = 1'b0;
        tick();
        chk(grant == 0 && !bus_valid && restart == 0, "R1 after reset", int'(grant), 0);

        // R4 / R3 / R2 / R10 / R7 sweep: every last index and every request mask
        for (int s = 0; s < N; s++) begin
            for (int m = 1; m < 16; m++) begin
                int w;
                set_req(s, 1'b1, addr_of(s), 2'd0);
                tick();
                chk(grant == 4'(1 << s), "R3 solo grant", int'(grant), 1 << s);
                req_valid = '0;
                done[s] = 1'b1;
                tick();
                done = '0;
                chk(grant == 0 && !bus_valid, "R7 gap after release", int'(grant), 0);
                for (int i = 0; i < N; i++)
                    set_req(i, m[i], addr_of(i), 2'((i + m) % 4));
                w = -1;
                for (int k = 1; k <= N; k++)
                    if (w < 0 && m[(s + k) % N]) w = (s + k) % N;
                tick();
                chk(grant == 4'(1 << w), "R4 round-robin winner", int'(grant), 1 << w);
                chk(bus_valid && int'(bus_owner) == w, "R2 owner index", int'(bus_owner), w);
                chk(bus_addr == addr_of(w), "R3 broadcast address", int'(bus_addr), int'(addr_of(w)));
                chk(int'(bus_cmd) == (w + m) % 4, "R10 broadcast command", int'(bus_cmd), (w + m) % 4);
                req_valid = '0;
                done[w] = 1'b1;
                tick();
                done = '0;
                chk(grant == 0, "R6 release", int'(grant), 0);
            end
        end

        // R5 / R6: hold against input changes and foreign done
        set_req(1, 1'b1, 8'h21, 2'd1);
        tick();
        chk(grant == 4'b0010, "R3 directed grant", int'(grant), 2);
        set_req(1, 1'b1, 8'h99, 2'd3);
        done[0] = 1'b1;
        tick();
        chk(grant == 4'b0010, "R6 foreign done ignored", int'(grant), 2);
        chk(bus_addr == 8'h21, "R5 address stable", int'(bus_addr), 'h21);
        chk(bus_cmd == 2'd1, "R5 command stable", int'(bus_cmd), 1);
        done = '0;
        req_valid = '0;
        done[1] = 1'b1;
        tick();
        done = '0;
        chk(grant == 0, "R6 owner done releases", int'(grant), 0);

        // R8 / R9: conflicts on the same block
        set_req(0, 1'b1, 8'h40, 2'd1);
        tick();
        chk(grant == 4'b0001, "R3 owner 0", int'(grant), 1);
        set_req(1, 1'b1, 8'h43, 2'd0);
        set_req(2, 1'b1, 8'h50, 2'd0);
        #1;
        chk(restart == 4'b0010, "R8 same block other offset", int'(restart), 2);
        tick();
        chk(restart == 4'b0000, "R8 single-cycle pulse", int'(restart), 0);
        set_req(3, 1'b1, 8'h41, 2'd2);
        #1;
        chk(restart == 4'b1000, "R8 late arrival conflict", int'(restart), 8);
        tick();
        chk(restart == 4'b0000, "R8 pulse ends", int'(restart), 0);
        req_valid[0] = 1'b0;
        done[0] = 1'b1;
        tick();
        done = '0;
        tick();
        chk(grant == 4'b0100, "R9 blocked requester skipped", int'(grant), 4);
        req_valid[2] = 1'b0;
        done[2] = 1'b1;
        tick();
        done = '0;
        tick(); tick();
        chk(grant == 0, "R9 stale requests not granted", int'(grant), 0);
        req_valid[1] = 1'b0;
        req_valid[3] = 1'b0;
        tick();
        set_req(1, 1'b1, 8'h43, 2'd1);
        tick();
        chk(grant == 4'b0010, "R9 reissued request granted", int'(grant), 2);
        chk(bus_cmd == 2'd1, "R10 reissued command", int'(bus_cmd), 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule